// File: doc/BRIEF.md
# Gated Field-Output Enable Sequencer

This block sits in a remote I/O node that takes both data and supply over one cable. It decides when field outputs may be driven. It watches a supply-good flag, an undervoltage flag, the link-up status and a timing tick. It keeps every output locked until the supply is good and the link has stayed up, with no drop, for a programmed number of ticks. It then releases the essential outputs first and the heavy loads a further programmed number of ticks later, so the step current is split into two smaller steps.

When the supply fails while outputs are live, the block forces safe-state on the next clock edge. It measures the length of the dip in ticks. A short dip keeps the outputs in safe-state until a fresh stability window has passed, and then releases them again in two stages. A dip that reaches the long-sag threshold sends the machine back to its locked start, so the whole bring-up order runs again. Once the outputs are released, link drops only add to a flap counter and never change the outputs. Every milestone is reported as a one-cycle event carrying a code and a tick timestamp, for an external logger.

Top module: `output_gate_seq`

## Requirements
- R1: After reset, en_essential, en_heavy, safe_state and ev_valid are low and flap_count is zero.
- R2: Supply is good when pwr_good is high and uv_flag is low. With the supply good, the block reports the supply-ready event. After that, link_up high reports the link-up event. en_essential rises only after link_up has stayed high for cfg_stable_ticks ticks (a setting of 0 acts as 1).
- R3: Each falling edge of link_up, except in the locked start state, adds one to flap_count. A drop during the stability window restarts the window, and no output is released while the link is down.
- R4: en_heavy rises cfg_heavy_ticks ticks after en_essential (a setting of 0 acts as 1). en_heavy is never high while en_essential is low.
- R5: While outputs are released and the supply is good, a link drop changes neither en_essential nor en_heavy.
- R6: Supply loss while outputs are released drives safe_state high and both enables low at the next clock edge. It also reports the safe-entry event. safe_state is never high together with either enable.
- R7: The dip length is the number of ticks seen at clock edges while the supply was bad, counted from the entry edge. It is placed on dip_len when the supply returns, together with the dip-end event.
- R8: A dip shorter than cfg_long_ticks keeps safe_state high until the link and supply have stayed good for cfg_stable_ticks ticks. Then the safe-exit event is reported and en_essential is released, followed by en_heavy after the heavy delay.
- R9: A dip of cfg_long_ticks ticks or more reports the safe-exit event on the cycle after the dip-end event. It then restarts from the locked state, so the supply-ready, link-up, gate-open and full-operation events all occur again.
- R10: Events are single-cycle ev_valid pulses. ev_code encodes supply-ready=0, link-up=1, gate-open=2, full-operation=3, safe-entry=4, safe-exit=5 and dip-end=6. ev_stamp is the number of ticks counted before the clock edge that raised the event.
- R11: Supply loss before the outputs are released returns the block to the locked state with no event and without safe_state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timing pulse for all windows and stamps |
| pwr_good | input | 1 | Supply-good flag from the input monitor |
| uv_flag | input | 1 | Undervoltage flag from the input monitor |
| link_up | input | 1 | Link status |
| cfg_stable_ticks | input | CW | Required link-stable window in ticks |
| cfg_heavy_ticks | input | CW | Delay from essential to heavy enable in ticks |
| cfg_long_ticks | input | CW | Dip length at or above which a dip counts as a long sag |
| en_essential | output | 1 | Essential output enable |
| en_heavy | output | 1 | Heavy-load enable |
| safe_state | output | 1 | Outputs held in safe-state after a supply dip |
| ev_valid | output | 1 | Event strobe |
| ev_code | output | 3 | Event code |
| ev_stamp | output | TW | Tick timestamp of the event |
| flap_count | output | FW | Count of link drops |
| dip_len | output | CW | Length of the most recent dip in ticks |

## Verification
The assertions assume that the supply flags and link_up are synchronous to clk and held steady between the stimulus changes. They also assume the configuration inputs stay constant while the machine runs. The bench sets the configuration once before releasing reset and changes pwr_good, uv_flag and link_up only on falling clock edges. It drives tick as a single-cycle pulse every fourth clock. The dip lengths are chosen to fall clearly on either side of the long-sag threshold, so the short and long classifications are never borderline.

// File: rtl/output_gate_seq.sv
module output_gate_seq #(
  parameter int CW = 16,
  parameter int TW = 32,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          pwr_good,
  input  logic          uv_flag,
  input  logic          link_up,
  input  logic [CW-1:0] cfg_stable_ticks,
  input  logic [CW-1:0] cfg_heavy_ticks,
  input  logic [CW-1:0] cfg_long_ticks,
  output logic          en_essential,
  output logic          en_heavy,
  output logic          safe_state,
  output logic          ev_valid,
  output logic [2:0]    ev_code,
  output logic [TW-1:0] ev_stamp,
  output logic [FW-1:0] flap_count,
  output logic [CW-1:0] dip_len
);

  typedef enum logic [2:0] {LOCKED, WAIT_LINK, STABLE_WAIT, STAGE1, ENABLED, SAFE} st_t;

  localparam logic [2:0] EV_PWR   = 3'd0;
  localparam logic [2:0] EV_LINK  = 3'd1;
  localparam logic [2:0] EV_GATE  = 3'd2;
  localparam logic [2:0] EV_FULL  = 3'd3;
  localparam logic [2:0] EV_SENT  = 3'd4;
  localparam logic [2:0] EV_SEXIT = 3'd5;
  localparam logic [2:0] EV_DIP   = 3'd6;
  localparam logic [CW-1:0] CNT_MAX = '1;

  st_t           st, st_n;
  logic [CW-1:0] cnt, cnt_n, dip_cnt, dip_cnt_n;
  logic          dipping, dipping_n, link_q;
  logic [TW-1:0] ts;
  logic          ev_n;
  logic [2:0]    code_n;
  logic [CW-1:0] stab_lim, heavy_lim;
  logic [CW:0]   cnt_inc;
  logic          pwr_ok, link_fall, stab_done, heavy_done, dip_long;

  assign pwr_ok     = pwr_good & ~uv_flag;
  assign link_fall  = link_q & ~link_up & (st != LOCKED);
  assign stab_lim   = (cfg_stable_ticks == '0) ? CW'(1) : cfg_stable_ticks;
  assign heavy_lim  = (cfg_heavy_ticks == '0) ? CW'(1) : cfg_heavy_ticks;
  assign cnt_inc    = {1'b0, cnt} + (CW+1)'(1);
  assign stab_done  = cnt_inc >= {1'b0, stab_lim};
  assign heavy_done = cnt_inc >= {1'b0, heavy_lim};
  assign dip_long   = dip_cnt >= cfg_long_ticks;

  assign en_essential = (st == STAGE1) || (st == ENABLED);
  assign en_heavy     = (st == ENABLED);
  assign safe_state   = (st == SAFE);

  always_comb begin
    st_n      = st;
    cnt_n     = cnt;
    dip_cnt_n = dip_cnt;
    dipping_n = dipping;
    ev_n      = 1'b0;
    code_n    = EV_PWR;
    case (st)
      LOCKED: begin
        cnt_n = '0;
        if (pwr_ok) begin
          st_n = WAIT_LINK; ev_n = 1'b1; code_n = EV_PWR;
        end
      end
      WAIT_LINK: begin
        cnt_n = '0;
        if (!pwr_ok) st_n = LOCKED;
        else if (link_up) begin
          st_n = STABLE_WAIT; ev_n = 1'b1; code_n = EV_LINK;
        end
      end
      STABLE_WAIT: begin
        if (!pwr_ok) st_n = LOCKED;
        else if (!link_up) st_n = WAIT_LINK;
        else if (tick) begin
          if (stab_done) begin
            st_n = STAGE1; cnt_n = '0; ev_n = 1'b1; code_n = EV_GATE;
          end else cnt_n = cnt_inc[CW-1:0];
        end
      end
      STAGE1, ENABLED: begin
        if (!pwr_ok) begin
          st_n = SAFE; ev_n = 1'b1; code_n = EV_SENT;
          dipping_n = 1'b1; cnt_n = '0;
          dip_cnt_n = tick ? CW'(1) : '0;
        end else if (st == STAGE1 && tick) begin
          if (heavy_done) begin
            st_n = ENABLED; cnt_n = '0; ev_n = 1'b1; code_n = EV_FULL;
          end else cnt_n = cnt_inc[CW-1:0];
        end
      end
      SAFE: begin
        if (!pwr_ok) begin
          cnt_n = '0;
          if (!dipping) begin
            dipping_n = 1'b1;
            dip_cnt_n = tick ? CW'(1) : '0;
          end else if (tick && dip_cnt != CNT_MAX) dip_cnt_n = dip_cnt + CW'(1);
        end else if (dipping) begin
          dipping_n = 1'b0; cnt_n = '0; ev_n = 1'b1; code_n = EV_DIP;
        end else if (dip_long) begin
          st_n = LOCKED; ev_n = 1'b1; code_n = EV_SEXIT;
        end else if (!link_up) cnt_n = '0;
        else if (tick) begin
          if (stab_done) begin
            st_n = STAGE1; cnt_n = '0; ev_n = 1'b1; code_n = EV_SEXIT;
          end else cnt_n = cnt_inc[CW-1:0];
        end
      end
      default: st_n = LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= LOCKED;
      cnt        <= '0;
      dip_cnt    <= '0;
      dipping    <= 1'b0;
      link_q     <= 1'b0;
      ts         <= '0;
      flap_count <= '0;
      ev_valid   <= 1'b0;
      ev_code    <= '0;
      ev_stamp   <= '0;
      dip_len    <= '0;
    end else begin
      st         <= st_n;
      cnt        <= cnt_n;
      dip_cnt    <= dip_cnt_n;
      dipping    <= dipping_n;
      link_q     <= link_up;
      ts         <= ts + TW'(tick);
      flap_count <= flap_count + FW'(link_fall);
      ev_valid   <= ev_n;
      ev_code    <= code_n;
      ev_stamp   <= ts;
      if (ev_n && code_n == EV_DIP) dip_len <= dip_cnt;
    end
  end

  AST_HEAVY_NEEDS_ESS: assert property (@(posedge clk) disable iff (!rst_n)
    en_heavy |-> en_essential); // R4
  AST_HEAVY_AFTER_ESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_heavy) |-> $past(en_essential)); // R4
  AST_GATE_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_essential) |-> ($past(link_up) && $past(pwr_ok))); // R2
  AST_SAFE_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    safe_state |-> (!en_essential && !en_heavy)); // R6
  AST_LOSS_TO_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_essential && !pwr_ok) |=> (safe_state && !en_essential)); // R6
  AST_FLAP_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (en_essential && pwr_ok && !link_up) |=> en_essential); // R5
  AST_FLAP_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (flap_count != $past(flap_count)) |-> ($past(link_up, 2) && !$past(link_up))); // R3
  AST_EARLY_LOSS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_essential && !safe_state && !pwr_ok) |=> !safe_state); // R11

endmodule

// File: tb/sim_output_gate_seq.sv
module sim_output_gate_seq;
  localparam int CW = 16, TW = 32, FW = 16;
  localparam int STAB = 3, HEAVY = 2, LONGT = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tick, pwr_good, uv_flag, link_up;
  logic [CW-1:0] cfg_stable_ticks, cfg_heavy_ticks, cfg_long_ticks;
  logic en_essential, en_heavy, safe_state, ev_valid;
  logic [2:0] ev_code;
  logic [TW-1:0] ev_stamp;
  logic [FW-1:0] flap_count;
  logic [CW-1:0] dip_len;

  output_gate_seq #(.CW(CW), .TW(TW), .FW(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_good(pwr_good), .uv_flag(uv_flag),
    .link_up(link_up), .cfg_stable_ticks(cfg_stable_ticks), .cfg_heavy_ticks(cfg_heavy_ticks),
    .cfg_long_ticks(cfg_long_ticks), .en_essential(en_essential), .en_heavy(en_heavy),
    .safe_state(safe_state), .ev_valid(ev_valid), .ev_code(ev_code), .ev_stamp(ev_stamp),
    .flap_count(flap_count), .dip_len(dip_len));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [2:0] exp_q[$];
  int unsigned ticks_done = 0, prev_ticks = 0, dip_ticks = 0;
  int unsigned stamp_of[8];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    prev_ticks = ticks_done;
    if (rst_n && tick) ticks_done++;
    if (rst_n && !(pwr_good && !uv_flag) && tick) dip_ticks++;
  end

  initial begin
    tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  // scoreboard monitor: R10 code and stamp of every event
  always @(negedge clk) begin
    if (rst_n && ev_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected event code", int'(ev_code), -1);
      end else begin
        logic [2:0] e;
        e = exp_q.pop_front();
        chk(ev_code == e, "R10 event code", int'(ev_code), int'(e));
        chk(ev_stamp == prev_ticks, "R10 event stamp", int'(ev_stamp), int'(prev_ticks));
        stamp_of[ev_code] = ev_stamp;
      end
    end
  end

  task automatic wait_drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(exp_q.size() == 0, "R10 pending events", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pwr_good = 1'b0; uv_flag = 1'b0; link_up = 1'b0;
    cfg_stable_ticks = CW'(STAB); cfg_heavy_ticks = CW'(HEAVY); cfg_long_ticks = CW'(LONGT);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!en_essential && !en_heavy, "R1 enables after reset", {en_essential, en_heavy}, 0);
    chk(!safe_state && !ev_valid, "R1 safe/event after reset", {safe_state, ev_valid}, 0);
    chk(flap_count == 0, "R1 flap count after reset", flap_count, 0);

    // R11: early supply loss
    exp_q.push_back(3'd0);
    pwr_good = 1'b1;
    wait_drain();
    pwr_good = 1'b0;
    repeat (12) @(negedge clk);
    chk(!safe_state, "R11 no safe-state before release", safe_state, 0);

    // R2 / R3: bring-up with a flap inside the window
    exp_q.push_back(3'd0);
    pwr_good = 1'b1;
    wait_drain();
    exp_q.push_back(3'd1);
    link_up = 1'b1;
    wait_drain();
    repeat (5) @(negedge clk);
    link_up = 1'b0;
    repeat (2) @(negedge clk);
    chk(flap_count == 1, "R3 flap counted", flap_count, 1);
    repeat (20) @(negedge clk);
    chk(!en_essential, "R3 no release while link down", en_essential, 0);
    exp_q.push_back(3'd1);
    exp_q.push_back(3'd2);
    link_up = 1'b1;
    wait_drain();
    chk(en_essential && !en_heavy, "R4 essential before heavy", {en_essential, en_heavy}, 2);
    chk((stamp_of[2] - stamp_of[1]) inside {STAB - 1, STAB}, "R2 window length",
        int'(stamp_of[2] - stamp_of[1]), STAB);
    exp_q.push_back(3'd3);
    wait_drain();
    chk(en_essential && en_heavy, "R4 heavy released", {en_essential, en_heavy}, 3);
    chk((stamp_of[3] - stamp_of[2]) inside {HEAVY - 1, HEAVY}, "R4 heavy delay",
        int'(stamp_of[3] - stamp_of[2]), HEAVY);

    // R5: link flap while released
    link_up = 1'b0;
    repeat (3) @(negedge clk);
    chk(flap_count == 2, "R5 flap counted while released", flap_count, 2);
    chk(en_essential && en_heavy, "R5 enables unchanged on flap", {en_essential, en_heavy}, 3);
    link_up = 1'b1;
    repeat (4) @(negedge clk);
    chk(en_essential && en_heavy, "R5 enables unchanged on relink", {en_essential, en_heavy}, 3);

    // R6 / R7 / R8: short dip
    dip_ticks = 0;
    exp_q.push_back(3'd4);
    uv_flag = 1'b1;
    @(negedge clk);
    chk(safe_state && !en_essential && !en_heavy, "R6 safe at once",
        {safe_state, en_essential, en_heavy}, 4);
    repeat (5) @(negedge clk);
    exp_q.push_back(3'd6);
    exp_q.push_back(3'd5);
    exp_q.push_back(3'd3);
    uv_flag = 1'b0;
    repeat (3) @(negedge clk);
    chk(safe_state && !en_essential, "R8 held safe in window", {safe_state, en_essential}, 2);
    wait_drain();
    chk(dip_len == dip_ticks, "R7 short dip length", dip_len, dip_ticks);
    chk(dip_ticks < LONGT, "R8 dip classed short", dip_ticks, LONGT - 1);
    chk(!safe_state && en_essential && en_heavy, "R8 re-released after short dip",
        {safe_state, en_essential, en_heavy}, 3);

    // R9: long sag restarts from the locked state
    dip_ticks = 0;
    exp_q.push_back(3'd4);
    pwr_good = 1'b0;
    repeat (24) @(negedge clk);
    chk(safe_state, "R6 safe during long sag", safe_state, 1);
    exp_q.push_back(3'd6);
    exp_q.push_back(3'd5);
    exp_q.push_back(3'd0);
    exp_q.push_back(3'd1);
    exp_q.push_back(3'd2);
    exp_q.push_back(3'd3);
    pwr_good = 1'b1;
    repeat (3) @(negedge clk);
    chk(!safe_state && !en_essential, "R9 locked after long sag", {safe_state, en_essential}, 0);
    wait_drain();
    chk(dip_len == dip_ticks, "R7 long dip length", dip_len, dip_ticks);
    chk(dip_ticks >= LONGT, "R9 dip classed long", dip_ticks, LONGT);
    chk(en_essential && en_heavy, "R9 full re-entry done", {en_essential, en_heavy}, 3);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R10 no stray events", exp_q.size(), 0);
    finish_run();
  end
endmodule